// File: doc/BRIEF.md
# Chainable SPI Register Slave

This block is a serial slave that holds a sixteen-entry register file of 16-bit words. A master reaches it by lowering an active-low select and then clocking 16-bit words on a serial clock that idles low. The first word of a sequence is a command. It carries a direction flag, an auto-increment flag and an address. Data words follow the command. The slave takes in every bit on the rising edge of the serial clock, most significant bit first. A read returns register contents on the serial output, and each bit changes on a falling edge.

While a command or a write is being received, every input bit is repeated on the serial output, so several slaves can be wired output-to-input behind one select line. All bus inputs are brought into a single system clock domain through two-stage synchronizers. The serial clock therefore has to be several times slower than the system clock. A read port on the side lets the register contents be observed directly.

Top module: `spi_chain_regslave`

## Requirements
- R1: After reset, every register holds zero and both `sdo_o` and `sdo_oe_o` are low.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first. In a command word, bit 15 selects the direction (1 = read, 0 = write) and bit 14 enables auto-increment. Bits 3:0 are the register address. Bits 13:4 are ignored.
- R3: The data word that follows a write command is stored at the addressed register.
- R4: While a command word or write data is being received, `sdo_o` repeats each incoming bit unchanged before the rising edge that samples it.
- R5: After a read command, the MSB of the addressed register appears on `sdo_o` following the command's final falling edge. Each later bit follows a falling edge.
- R6: With auto-increment set, successive write data words go to successive addresses. The address wraps from 15 to 0.
- R7: With auto-increment set, successive read data words come from successive addresses and wrap from 15 to 0.
- R8: Without auto-increment, a command takes exactly one data word. The next word is decoded as a new command.
- R9: Raising select at any point ends the sequence, and a partly received write word changes no register. The next word after select is lowered again is a command.
- R10: While select is high, `sdo_o` and `sdo_oe_o` are low. While select is low, `sdo_oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| sel_n_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| dbg_addr_i | input | 4 | Register file observation address |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | High when the serial output would be driven |
| dbg_data_o | output | 16 | Contents of the register at `dbg_addr_i` |

## Verification
There are three main ways a wrong internal state would show at the ports. A miscounted bit position lets a command be read as data, or the reverse. That error shows at the latest one word later, as a wrong register on the observation port or a read word shifted by one bit. A stale direction flag stops the output from echoing and shows within one bit time. A wrong address after auto-increment shows in the second word of a burst. An abort that fails to clear the sequencer shows on the first word after select returns, because that word would not be decoded as a command.

// File: rtl/spi_chain_regslave.sv
module spi_chain_regslave #(
  parameter int AW = 4,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          sel_n_i,
  input  logic          sdi_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [WW-1:0] dbg_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WW);

  logic [2:0] sclk_p;
  logic [1:0] sel_p, sdi_p;
  logic       rise, fall, sel, sdi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sel_p  <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk_i};
      sel_p  <= {sel_p[0], sel_n_i};
      sdi_p  <= {sdi_p[0], sdi_i};
    end

  assign rise = sclk_p[1] & ~sclk_p[2];
  assign fall = ~sclk_p[1] & sclk_p[2];
  assign sel  = ~sel_p[1];
  assign sdi  = sdi_p[1];

  logic [CW-1:0] bit_cnt;
  logic [WW-1:0] shreg, tx, word;
  logic [AW-1:0] addr;
  logic          in_data, rd_mode, autoinc, sdo_q, word_done;
  logic [WW-1:0] regs [DEPTH];

  assign word      = {shreg[WW-2:0], sdi};
  assign word_done = rise && (bit_cnt == CW'(WW-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      addr    <= '0;
      in_data <= 1'b0;
      rd_mode <= 1'b0;
      autoinc <= 1'b0;
      sdo_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (!sel) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
      rd_mode <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      if (rise) begin
        shreg   <= word;
        bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      end
      if (word_done) begin
        if (!in_data) begin
          in_data <= 1'b1;
          rd_mode <= word[WW-1];
          autoinc <= word[WW-2];
          addr    <= word[AW-1:0];
          tx      <= regs[word[AW-1:0]];
        end else begin
          if (!rd_mode) regs[addr] <= word;
          if (autoinc) begin
            addr <= AW'(addr + 1'b1);
            tx   <= regs[AW'(addr + 1'b1)];
          end else begin
            in_data <= 1'b0;
            rd_mode <= 1'b0;
          end
        end
      end
      if (rd_mode) begin
        if (fall) begin
          sdo_q <= tx[WW-1];
          tx    <= tx << 1;
        end
      end else begin
        sdo_q <= sdi;
      end
    end

  assign sdo_o      = sdo_q;
  assign sdo_oe_o   = sel;
  assign dbg_data_o = regs[dbg_addr_i];

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo_o);
  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!in_data && !rd_mode && bit_cnt == '0));
  p_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rd_mode) |=> sdo_o == $past(sdi));
  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && word_done && in_data && !rd_mode) |=> regs[$past(addr)] == $past(word));
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && word_done && in_data && autoinc) |=> addr == AW'($past(addr) + 1'b1));
  p_read_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_mode && fall) |=> sdo_o == $past(tx[WW-1]));
endmodule

// File: tb/spi_chain_regslave_bench.sv
module spi_chain_regslave_bench;
  localparam int HALF = 8;
  localparam int GAP  = 12;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
  logic [3:0]  dbg_addr = '0;
  logic        sdo, sdo_oe;
  logic [15:0] dbg_data;
  logic [15:0] mdl [16];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_chain_regslave u_spi_chain_regslave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
    .dbg_addr_i(dbg_addr), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .dbg_data_o(dbg_data));

  // {addr, data}
  localparam logic [19:0] VEC [8] = '{
    {4'h0, 16'hA5C3}, {4'h1, 16'h0001}, {4'h2, 16'h8000}, {4'h7, 16'hFFFF},
    {4'h9, 16'h1234}, {4'hB, 16'h0F0F}, {4'hD, 16'hC0DE}, {4'hF, 16'h5A5A}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    for (int i = 15; i > 15 - nbits; i--) begin
      sdi = w[i];
      repeat (HALF) @(negedge clk);
      r[i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic select(input logic on);
    sel_n = ~on;
    sdi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic peek(input logic [3:0] a, input string req);
    dbg_addr = a;
    #1;
    check(req, dbg_data, mdl[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 sdo", {15'b0, sdo}, 16'h0);
    check("R1 oe", {15'b0, sdo_oe}, 16'h0);
    for (int i = 0; i < 16; i++) peek(4'(i), "R1 reg");

    // R3/R4/R8: table of write pairs in one select window
    select(1'b1);
    check("R10 oe selected", {15'b0, sdo_oe}, 16'h1);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] cmd;
      cmd = {12'h000, VEC[k][19:16]};
      xfer(cmd, 16, r);
      check("R4 echo cmd", r, cmd);
      xfer(VEC[k][15:0], 16, r);
      check("R4 echo data", r, VEC[k][15:0]);
      mdl[VEC[k][19:16]] = VEC[k][15:0];
    end
    select(1'b0);
    check("R10 sdo idle", {15'b0, sdo}, 16'h0);
    check("R10 oe idle", {15'b0, sdo_oe}, 16'h0);
    for (int k = 0; k < 8; k++) peek(VEC[k][19:16], "R3 R8 stored");

    // R5: read back every table entry
    select(1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] cmd;
      cmd = {12'h800, VEC[k][19:16]};
      xfer(cmd, 16, r);
      check("R4 echo read cmd", r, cmd);
      xfer(16'h0000, 16, r);
      check("R5 read data", r, VEC[k][15:0]);
    end
    select(1'b0);

    // R2: ignored address bits 13:4
    select(1'b1);
    xfer(16'h3FF3, 16, r);
    xfer(16'hBEEF, 16, r);
    mdl[3] = 16'hBEEF;
    select(1'b0);
    peek(4'h3, "R2 high addr bits ignored");

    // R6: auto-increment write 14,15,0
    select(1'b1);
    xfer(16'h400E, 16, r);
    xfer(16'h1111, 16, r); check("R4 echo burst", r, 16'h1111);
    xfer(16'h2222, 16, r);
    xfer(16'h3333, 16, r);
    mdl[14] = 16'h1111; mdl[15] = 16'h2222; mdl[0] = 16'h3333;
    select(1'b0);
    peek(4'hE, "R6 burst 0");
    peek(4'hF, "R6 burst 1");
    peek(4'h0, "R6 burst wrap");

    // R7: auto-increment read 15,0,1
    select(1'b1);
    xfer(16'hC00F, 16, r);
    xfer(16'h0000, 16, r); check("R7 read 15", r, mdl[15]);
    xfer(16'h0000, 16, r); check("R7 read wrap 0", r, mdl[0]);
    xfer(16'h0000, 16, r); check("R7 read 1", r, mdl[1]);
    select(1'b0);

    // R9: abort part-way through a write data word
    select(1'b1);
    xfer(16'h0009, 16, r);
    xfer(16'hDEAD, 8, r);
    select(1'b0);
    check("R10 sdo after abort", {15'b0, sdo}, 16'h0);
    peek(4'h9, "R9 partial write discarded");
    // abort in mid-command, then a fresh command must decode
    select(1'b1);
    xfer(16'h8000, 5, r);
    select(1'b0);
    select(1'b1);
    xfer(16'h8009, 16, r);
    xfer(16'h0000, 16, r);
    check("R9 command after abort", r, mdl[9]);
    select(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule